// File: doc/BRIEF.md
# Converter Soft-Start and Fault Sequencer

This block supervises the duty-cycle path of a digitally controlled switching converter. It sits between the voltage-loop compensator and the PWM generator. The compensator's requested duty passes through the block, which limits it according to the converter's operating phase. The block also asserts a shutdown line toward the PWM generator whenever the power stage must not switch.

After reset the sequencer waits in a lockout phase. It leaves lockout once enable is high and the digitized input supply has been qualified. Qualification uses two thresholds with hysteresis: the supply must climb to the upper threshold to become valid, and it is dropped only when it falls under the lower one. A soft-start phase then raises a duty ceiling in equal steps, one step per switching period, from zero to full scale. After that the block runs with the compensator duty passed through unchanged.

While the converter switches, an inductor current above its threshold or an output voltage above its threshold latches the sequencer into a fault phase within one clock. Two flags show which condition caused the trip. The only way out of the fault phase is to drop enable; the converter restarts when enable is raised again.

Top module: `ss_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, the state code is 0 (lockout), pwm_off is 1, duty_lim is 0 and both fault flags are 0.
- R2: The supply becomes qualified at the first clock edge where vin >= uv_on_th. At the following edge, if en is high, the state moves from lockout (code 0) to soft-start (code 1). While vin stays under uv_on_th the block stays in lockout.
- R3: The soft-start ceiling is floor(s*(2^DUTY_W-1)/RAMP_STEPS), where s starts at 0 on entry and grows by one every PERIOD_CLKS clocks up to RAMP_STEPS. One clock after s reaches RAMP_STEPS the state becomes run (code 2).
- R4: A qualified supply is disqualified only at an edge where vin < uv_off_th. One edge after that, soft-start or run falls back to lockout. Values between the two thresholds change nothing.
- R5: In soft-start duty_lim is the smaller of duty_req and the ceiling. In run it equals duty_req. In lockout and fault it is 0. pwm_off is 0 exactly in soft-start and run.
- R6: In soft-start or run, i_sense > oc_th (strictly greater) moves the state to fault (code 3) at the next edge and sets flag_oc. An i_sense equal to oc_th has no effect.
- R7: In soft-start or run, vout > ov_th (strictly greater) moves the state to fault at the next edge and sets flag_ov. A vout equal to ov_th has no effect. When both trips arrive together, both flags are set.
- R8: Fault is held while en stays high, whatever the sensed values. Dropping en moves the state to lockout with the flags kept. The flags clear when soft-start is next entered.
- R9: Dropping en in soft-start or run returns the state to lockout at the next edge. A trip has priority over loss of enable.
- R10: state_o encodes lockout=0, soft-start=1, run=2, fault=3.
- R11: In lockout, overcurrent and overvoltage inputs are ignored: no flag is set and the state stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| vin | input | ADC_W | Digitized input supply voltage |
| vout | input | ADC_W | Digitized output voltage |
| i_sense | input | ADC_W | Digitized inductor current |
| uv_on_th | input | ADC_W | Supply qualification (rising) threshold |
| uv_off_th | input | ADC_W | Supply disqualification (falling) threshold |
| ov_th | input | ADC_W | Overvoltage trip threshold |
| oc_th | input | ADC_W | Overcurrent trip threshold |
| duty_req | input | DUTY_W | Duty requested by the compensator |
| duty_lim | output | DUTY_W | Duty forwarded to the PWM generator |
| pwm_off | output | 1 | Shutdown request to the PWM generator |
| state_o | output | 2 | Sequencer state code |
| flag_oc | output | 1 | Latched overcurrent cause |
| flag_ov | output | 1 | Latched overvoltage cause |

## Verification
The assertions assume that uv_off_th does not exceed uv_on_th. They also assume the thresholds stay constant during an operating interval, so that a qualification decision is always made against stable limits. The stimulus follows both rules: it sets the thresholds once, before reset is released, with a 20-count gap between the rising and falling levels. Only the sensed values, the enable and the requested duty change, and each changes at the falling clock edge, so every trip and qualification lands on a defined rising edge.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;

    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_SOFT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic oc;
        logic ov;
    } trip_t;

    function automatic logic is_live(seq_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/ss_uvlo.sv
`timescale 1ns/1ps
module ss_uvlo #(
    parameter int ADC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADC_W-1:0] vin,
    input  logic [ADC_W-1:0] on_th,
    input  logic [ADC_W-1:0] off_th,
    output logic             supply_ok
);

    always_ff @(posedge clk) begin
        if (rst)
            supply_ok <= 1'b0;
        else if (!supply_ok && (vin >= on_th))
            supply_ok <= 1'b1;
        else if (supply_ok && (vin < off_th))
            supply_ok <= 1'b0;
    end

    // R2
    stay_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok && (vin < on_th)) |=> !supply_ok);

    // R4
    hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && (vin >= off_th)) |=> supply_ok);

endmodule

// File: rtl/ss_ramp.sv
`timescale 1ns/1ps
module ss_ramp #(
    parameter int DUTY_W      = 10,
    parameter int PERIOD_CLKS = 80,
    parameter int RAMP_STEPS  = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [DUTY_W-1:0] ceiling,
    output logic              done
);

    localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
    localparam int SW = $clog2(RAMP_STEPS + 1);
    localparam int PW = SW + DUTY_W;

    logic [CW-1:0] tick_cnt;
    logic [SW-1:0] step;
    logic [PW-1:0] prod;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_cnt <= '0;
            step     <= '0;
        end else if (step != SW'(RAMP_STEPS)) begin
            if (tick_cnt == CW'(PERIOD_CLKS - 1)) begin
                tick_cnt <= '0;
                step     <= step + 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    assign prod    = {{DUTY_W{1'b0}}, step} * PW'((2 ** DUTY_W) - 1);
    assign ceiling = DUTY_W'(prod / PW'(RAMP_STEPS));
    assign done    = (step == SW'(RAMP_STEPS));

    // R3
    ceil_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (ceiling >= $past(ceiling)));

    // R3
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (run && done) |=> (!run || done));

endmodule

// File: rtl/ss_fsm.sv
`timescale 1ns/1ps
module ss_fsm
    import ss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       supply_ok,
    input  trip_t      trip,
    input  logic       ramp_done,
    output seq_state_e state,
    output trip_t      cause
);

    seq_state_e nxt;
    logic       any_trip;

    assign any_trip = trip.oc || trip.ov;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCK:  if (en && supply_ok) nxt = ST_SOFT;
            ST_SOFT: begin
                if (any_trip)               nxt = ST_FAULT;
                else if (!en || !supply_ok) nxt = ST_LOCK;
                else if (ramp_done)         nxt = ST_RUN;
            end
            ST_RUN: begin
                if (any_trip)               nxt = ST_FAULT;
                else if (!en || !supply_ok) nxt = ST_LOCK;
            end
            ST_FAULT: if (!en) nxt = ST_LOCK;
            default:  nxt = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOCK;
            cause <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_FAULT && state != ST_FAULT)
                cause <= trip;
            else if (nxt == ST_SOFT && state == ST_LOCK)
                cause <= '0;
        end
    end

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT && en) |=> (state == ST_FAULT));

    // R6
    trip_react_chk: assert property (@(posedge clk) disable iff (rst)
        (is_live(state) && any_trip) |=> (state == ST_FAULT));

    // R7
    cause_known_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT) |-> (cause.oc || cause.ov));

    // R11
    lock_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK) |=> (state != ST_FAULT));

endmodule

// File: rtl/ss_sequencer.sv
`timescale 1ns/1ps
module ss_sequencer
    import ss_pkg::*;
#(
    parameter int ADC_W       = 12,
    parameter int DUTY_W      = 10,
    parameter int PERIOD_CLKS = 80,
    parameter int RAMP_STEPS  = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADC_W-1:0]  vin,
    input  logic [ADC_W-1:0]  vout,
    input  logic [ADC_W-1:0]  i_sense,
    input  logic [ADC_W-1:0]  uv_on_th,
    input  logic [ADC_W-1:0]  uv_off_th,
    input  logic [ADC_W-1:0]  ov_th,
    input  logic [ADC_W-1:0]  oc_th,
    input  logic [DUTY_W-1:0] duty_req,
    output logic [DUTY_W-1:0] duty_lim,
    output logic              pwm_off,
    output logic [1:0]        state_o,
    output logic              flag_oc,
    output logic              flag_ov
);

    localparam logic [DUTY_W-1:0] FULL_SCALE = '1;

    seq_state_e        state;
    trip_t             trip;
    trip_t             cause;
    logic              supply_ok;
    logic              ramp_done;
    logic [DUTY_W-1:0] ceiling;
    logic [DUTY_W-1:0] cap;
    logic              live;

    assign trip.oc = (i_sense > oc_th);
    assign trip.ov = (vout > ov_th);

    ss_uvlo #(.ADC_W(ADC_W)) uvlo_i (
        .clk       (clk),
        .rst       (rst),
        .vin       (vin),
        .on_th     (uv_on_th),
        .off_th    (uv_off_th),
        .supply_ok (supply_ok)
    );

    ss_ramp #(
        .DUTY_W      (DUTY_W),
        .PERIOD_CLKS (PERIOD_CLKS),
        .RAMP_STEPS  (RAMP_STEPS)
    ) ramp_i (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_SOFT),
        .ceiling (ceiling),
        .done    (ramp_done)
    );

    ss_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .supply_ok (supply_ok),
        .trip      (trip),
        .ramp_done (ramp_done),
        .state     (state),
        .cause     (cause)
    );

    assign live     = is_live(state);
    assign cap      = (state == ST_RUN) ? FULL_SCALE : ceiling;
    assign duty_lim = !live ? '0 : ((duty_req < cap) ? duty_req : cap);
    assign pwm_off  = !live;
    assign state_o  = state;
    assign flag_oc  = cause.oc;
    assign flag_ov  = cause.ov;

    // R5
    duty_cap_chk: assert property (@(posedge clk) disable iff (rst)
        duty_lim <= duty_req);

    // R9
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !en && !trip.oc && !trip.ov) |=> (state == ST_LOCK));

endmodule

// File: tb/ss_sequencer_tb_top.sv
`timescale 1ns/1ps
module ss_sequencer_tb_top;

    localparam int ADC_W = 12;
    localparam int DW    = 8;
    localparam int PER   = 4;
    localparam int STEPS = 8;
    localparam int FULLV = 255;

    typedef struct {
        int    duty;
        bit    off;
        int    st;
        bit    oc;
        bit    ov;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [ADC_W-1:0] vin = '0, vout = '0, i_sense = '0;
    logic [ADC_W-1:0] uv_on_th = 12'd100, uv_off_th = 12'd80;
    logic [ADC_W-1:0] ov_th = 12'd200, oc_th = 12'd150;
    logic [DW-1:0]    duty_req = '0;
    logic [DW-1:0]    duty_lim;
    logic             pwm_off, flag_oc, flag_ov;
    logic [1:0]       state_o;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always #2 clk = ~clk;

    ss_sequencer #(
        .ADC_W(ADC_W), .DUTY_W(DW), .PERIOD_CLKS(PER), .RAMP_STEPS(STEPS)
    ) dut_i (
        .clk(clk), .rst(rst), .en(en), .vin(vin), .vout(vout),
        .i_sense(i_sense), .uv_on_th(uv_on_th), .uv_off_th(uv_off_th),
        .ov_th(ov_th), .oc_th(oc_th), .duty_req(duty_req),
        .duty_lim(duty_lim), .pwm_off(pwm_off), .state_o(state_o),
        .flag_oc(flag_oc), .flag_ov(flag_ov)
    );

    // driver side: queue the result expected after the coming rising edge
    task automatic expect_next(input int d, input bit off, input int st,
                               input bit oc, input bit ov, input string tag);
        exp_t e;
        e.duty = d; e.off = off; e.st = st; e.oc = oc; e.ov = ov; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int ramp_ceil(input int k);
        int s;
        s = k / PER;
        if (s > STEPS) s = STEPS;
        return (s * FULLV) / STEPS;
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // monitor side: compare one queued item per rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            bit   bad;
            e = q.pop_front();
            n_cmp++;
            bad = 0;
            if (int'(duty_lim) != e.duty) begin
                bad = 1;
                $display("FAIL %s duty_lim: actual %0d expected %0d", e.tag, duty_lim, e.duty);
            end
            if (pwm_off != e.off) begin
                bad = 1;
                $display("FAIL %s pwm_off: actual %0b expected %0b", e.tag, pwm_off, e.off);
            end
            if (int'(state_o) != e.st) begin
                bad = 1;
                $display("FAIL %s R10 state_o: actual %0d expected %0d", e.tag, state_o, e.st);
            end
            if (flag_oc != e.oc || flag_ov != e.ov) begin
                bad = 1;
                $display("FAIL %s flags oc/ov: actual %0b%0b expected %0b%0b",
                         e.tag, flag_oc, flag_ov, e.oc, e.ov);
            end
            if (bad) n_bad++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        expect_next(0, 1, 0, 0, 0, "R1 in reset");
        rst = 1'b0;
        expect_next(0, 1, 0, 0, 0, "R1 after reset");

        // R11 trips ignored while locked out (supply below rise level)
        en = 1'b1; vin = 12'd50; i_sense = 12'd300; vout = 12'd300;
        for (int i = 0; i < 3; i++) expect_next(0, 1, 0, 0, 0, "R11 trips in lockout");
        i_sense = '0; vout = '0;

        // R2 qualification at the rising threshold
        vin = 12'd99;
        for (int i = 0; i < 3; i++) expect_next(0, 1, 0, 0, 0, "R2 below rise");
        vin = 12'd100; duty_req = 8'd100;
        expect_next(0, 1, 0, 0, 0, "R2 qualify latency");

        // R3 ramp, capped by R5 minimum rule
        for (int k = 0; k <= PER * STEPS; k++)
            expect_next(min2(100, ramp_ceil(k)), 0, 1, 0, 0, "R3 ramp ceiling");
        expect_next(100, 0, 2, 0, 0, "R3 enter run");
        duty_req = 8'd255;
        expect_next(255, 0, 2, 0, 0, "R5 full duty in run");
        duty_req = 8'd37;
        expect_next(37, 0, 2, 0, 0, "R5 pass through");

        // R4 hysteresis
        vin = 12'd85;
        for (int i = 0; i < 3; i++) expect_next(37, 0, 2, 0, 0, "R4 between thresholds");
        vin = 12'd79;
        expect_next(37, 0, 2, 0, 0, "R4 drop latency");
        expect_next(0, 1, 0, 0, 0, "R4 drop to lockout");
        vin = 12'd95;
        for (int i = 0; i < 3; i++) expect_next(0, 1, 0, 0, 0, "R4 needs rise level");

        // restart, then R6 overcurrent
        vin = 12'd120;
        expect_next(0, 1, 0, 0, 0, "R2 requalify");
        idle(PER * STEPS + 2);
        expect_next(37, 0, 2, 0, 0, "R3 back in run");
        i_sense = 12'd150;
        expect_next(37, 0, 2, 0, 0, "R6 equal to threshold");
        i_sense = 12'd151;
        expect_next(0, 1, 3, 1, 0, "R6 overcurrent trip");
        i_sense = '0;
        for (int i = 0; i < 4; i++) expect_next(0, 1, 3, 1, 0, "R8 latched while enabled");
        en = 1'b0;
        expect_next(0, 1, 0, 1, 0, "R8 exit keeps flags");
        en = 1'b1;
        expect_next(0, 0, 1, 0, 0, "R8 restart clears flags");

        // R7 overvoltage during soft-start
        vout = 12'd200;
        expect_next(0, 0, 1, 0, 0, "R7 equal to threshold");
        vout = 12'd201;
        expect_next(0, 1, 3, 0, 1, "R7 overvoltage trip");
        vout = '0; en = 1'b0;
        expect_next(0, 1, 0, 0, 1, "R8 exit after ov");
        en = 1'b1;
        expect_next(0, 0, 1, 0, 0, "R8 second restart");

        // R9 enable loss in soft-start
        en = 1'b0;
        expect_next(0, 1, 0, 0, 0, "R9 enable dropped");
        en = 1'b1;
        expect_next(0, 0, 1, 0, 0, "R9 re-enter soft-start");

        // R7 simultaneous trips with priority over enable loss (R9)
        i_sense = 12'd200; vout = 12'd250; en = 1'b0;
        expect_next(0, 1, 3, 1, 1, "R7 R9 both trips win");
        i_sense = '0; vout = '0;
        expect_next(0, 1, 0, 1, 1, "R8 disabled fault exits");

        idle(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule